// File: doc/BRIEF.md
# Serviced Watchdog Timer

This peripheral guards a processor against hangs. Software programs a 32-bit reload value and a control word over a small word-addressed register bus. It then services the timer at intervals by writing a fixed restart key, which copies the reload value into a 32-bit down-counter. The counter decrements either on every bus clock or only on cycles where an external 1 MHz tick enable is high. If software stops servicing the timer, the count reaches zero. The block then raises any combination of a one-cycle reset request, a level interrupt and a level external output. A scope bit travels with the reset request and tells the reset controller whether to reset only the core or the full chip.

The register decode uses the low four address bits. The word at 0x0 reads back the live count. The word at 0x4 holds the reload value. The word at 0x8 takes the restart key and reads as zero. The word at 0xC holds the control bits:

| Bit | Meaning |
|-----|---------|
| 0 | count enable |
| 1 | reset request on expiry |
| 2 | interrupt on expiry |
| 3 | external output on expiry |
| 4 | decrement on the tick input instead of every bus clock |
| 5 | reset scope: 0 core-only, 1 full chip |

A three-state machine sequences the counter:
- IDLE: disabled, counter frozen.
- RUN: counting.
- EXPIRED: count is zero and the alarms are latched.

The transitions are:
- IDLE→RUN: enable is set.
- RUN→EXPIRED: the 1→0 decrement.
- EXPIRED→RUN: a valid restart key.
- RUN→IDLE and EXPIRED→IDLE: enable is cleared.

Top module: `wdg_top`

## Requirements
- R1: After reset, control reads 0x00000000, the reload value reads 0xFFFFFFFF, the count reads 0xFFFFFFFF, and all four alarm outputs are low.
- R2: A write with `bus_addr[1:0]==0` to 0x4 or 0xC stores the value; control keeps only bits 5:0 and reads zero above them. A read of 0x8 returns zero. A write to 0x0 has no effect. Any access with nonzero `bus_addr[1:0]` reads zero and writes nothing.
- R3: A write of exactly 0x00004755 to 0x8 loads the reload value into the counter at that clock edge, in every state, and clears both level alarms at the same edge.
- R4: A write to 0x8 of any other value, including one whose low 16 bits are 0x4755 but whose upper bits are nonzero, changes neither the count nor any output.
- R5: While control bit 0 is clear (IDLE), the counter holds its value and all alarm outputs stay low.
- R6: With control bit 4 clear, the first decrement happens on the second clock edge after the control write that sets bit 0, and the counter then drops by one per clock.
- R7: With control bit 4 set, the counter drops by one only on clock edges where `tick_1us` was high in the preceding cycle.
- R8: Expiry happens on the decrement from 1 to 0. The counter then stays at zero without wrapping, and a counter already at zero never triggers an expiry.
- R9: At expiry with control bit 1 set, `rst_req` is high for exactly one cycle, and `rst_full` equals control bit 5 in that cycle.
- R10: At expiry, `irq` rises if control bit 2 is set and `wdog_out` rises if bit 3 is set. Both stay high until a valid key write, or until a control write with bit 0 clear; either one clears them at that edge.
- R11: The sequence "control←0, reload←L, key, control←enable" produces no alarm before the counter has counted L steps from L, even if the timer was running or expired beforehand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | bus and counter clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick_1us | input | 1 | 1 MHz tick enable, one clock wide |
| bus_sel | input | 1 | register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | byte address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| rst_req | output | 1 | one-cycle reset request |
| rst_full | output | 1 | reset scope: 0 core-only, 1 full chip |
| irq | output | 1 | level interrupt |
| wdog_out | output | 1 | level external watchdog signal |

## Verification
The assertions check on every cycle:
- `rst_req` never lasts two cycles;
- a disabled timer keeps its count and keeps every alarm low;
- a key write loads the reload value;
- the count never rises except through a reload;
- `irq` only rises once the count is zero.

The exact expiry edge can only be shown by the bench's scenarios. They sweep reload values, alarm-enable combinations, scope and count source. They also cover the two-edge start latency, tick gating, the rejection of near-miss keys, the behaviour of a zero reload, and the disable/reload/key/enable sequence from a running or expired timer.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // FSM states of the countdown sequencer
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wdg_state_e;

    // control word, bit 5 down to bit 0
    typedef struct packed {
        logic scope_full;   // bit 5
        logic tick_sel;     // bit 4
        logic ext_en;       // bit 3
        logic irq_en;       // bit 2
        logic rst_en;       // bit 1
        logic run_en;       // bit 0
    } wdg_ctrl_t;

    localparam int unsigned CTRL_W = $bits(wdg_ctrl_t);

    // word index (address bits 3:2)
    localparam logic [1:0] IDX_STATUS = 2'd0;
    localparam logic [1:0] IDX_RELOAD = 2'd1;
    localparam logic [1:0] IDX_KICK   = 2'd2;
    localparam logic [1:0] IDX_CTRL   = 2'd3;

    // level alarm lanes
    localparam int unsigned LANE_IRQ = 0;
    localparam int unsigned LANE_EXT = 1;
    localparam int unsigned N_LANES  = 2;

endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h4755
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cnt,
    output wdg_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             kick,
    output logic             ctrl_off,
    output logic [CNT_W-1:0] bus_rdata
);

    localparam logic [CNT_W-1:0] KEY_WORD = {{(CNT_W-KEY_W){1'b0}}, KEY_VAL};

    logic       aligned;
    logic [1:0] idx;
    logic       wr_hit;
    logic       rd_hit;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[3:2];
    assign wr_hit  = bus_sel && bus_wr && aligned;
    assign rd_hit  = bus_sel && !bus_wr && aligned;

    // restart key: full-word exact match only
    assign kick     = wr_hit && (idx == IDX_KICK) && (bus_wdata == KEY_WORD);
    // control write that turns counting off
    assign ctrl_off = wr_hit && (idx == IDX_CTRL) && !bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '1;
        end else if (wr_hit) begin
            if (idx == IDX_CTRL) begin
                ctrl_q <= wdg_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end
            if (idx == IDX_RELOAD) begin
                reload_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (idx)
                IDX_STATUS: bus_rdata = cnt;
                IDX_RELOAD: bus_rdata = reload_q;
                IDX_KICK:   bus_rdata = '0;
                IDX_CTRL:   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdg_ctrl_t        ctrl_q,
    input  logic             tick_1us,
    input  logic             kick,
    input  logic             ctrl_off,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    wdg_state_e state_q;
    wdg_state_e state_d;
    logic       step;
    logic       dec;

    // decrement source: bus clock or external tick
    assign step   = ctrl_q.tick_sel ? tick_1us : 1'b1;
    assign dec    = (state_q == ST_RUN) && ctrl_q.run_en && step && (cnt_q != '0);
    assign expire = dec && (cnt_q == ONE) && !kick && !ctrl_off;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_q.run_en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ctrl_q.run_en)  state_d = ST_IDLE;
                else if (expire)     state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!ctrl_q.run_en)  state_d = ST_IDLE;
                else if (kick)       state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter: key reload has priority over decrement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (kick) begin
            cnt_q <= reload_q;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/wdg_alarm.sv
module wdg_alarm
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wdg_ctrl_t ctrl_q,
    input  logic      expire,
    input  logic      kick,
    input  logic      ctrl_off,
    output logic      rst_req,
    output logic      rst_full,
    output logic      irq,
    output logic      wdog_out
);

    logic                clr;
    logic [N_LANES-1:0]  lane_en;
    logic [N_LANES-1:0]  lane_q;

    assign clr = kick || ctrl_off || !ctrl_q.run_en;
    assign lane_en[LANE_IRQ] = ctrl_q.irq_en;
    assign lane_en[LANE_EXT] = ctrl_q.ext_en;

    // one-cycle reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire && ctrl_q.rst_en;
        end
    end

    // latched level alarms, clear wins over set
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[i] <= 1'b0;
            end else if (clr) begin
                lane_q[i] <= 1'b0;
            end else if (expire && lane_en[i]) begin
                lane_q[i] <= 1'b1;
            end
        end
    end

    assign rst_full = ctrl_q.scope_full;
    assign irq      = lane_q[LANE_IRQ];
    assign wdog_out = lane_q[LANE_EXT];

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h4755
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1us,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req,
    output logic        rst_full,
    output logic        irq,
    output logic        wdog_out
);

    wdg_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             kick;
    logic             ctrl_off;
    logic             expire;

    wdg_regfile #(
        .CNT_W  (CNT_W),
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cnt      (cnt_q),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .kick     (kick),
        .ctrl_off (ctrl_off),
        .bus_rdata(bus_rdata)
    );

    wdg_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_q  (ctrl_q),
        .tick_1us(tick_1us),
        .kick    (kick),
        .ctrl_off(ctrl_off),
        .reload_q(reload_q),
        .cnt_q   (cnt_q),
        .expire  (expire)
    );

    wdg_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_q  (ctrl_q),
        .expire  (expire),
        .kick    (kick),
        .ctrl_off(ctrl_off),
        .rst_req (rst_req),
        .rst_full(rst_full),
        .irq     (irq),
        .wdog_out(wdog_out)
    );

endmodule

// File: rtl/wdg_check.sv
module wdg_check #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             kick,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             rst_req,
    input logic             irq,
    input logic             wdog_out
);

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (!irq && !wdog_out && !rst_req));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_en) && !$past(kick)) |-> (cnt_q == $past(cnt_q)));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kick) |-> (cnt_q == $past(reload_q)));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(kick) |-> (cnt_q <= $past(cnt_q)));

    assert_irq_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt_q == '0));

endmodule

bind wdg_top wdg_check #(.CNT_W(CNT_W)) u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_en (ctrl_q.run_en),
    .kick    (kick),
    .reload_q(reload_q),
    .cnt_q   (cnt_q),
    .rst_req (rst_req),
    .irq     (irq),
    .wdog_out(wdog_out)
);

// File: tb/test_wdg_top.sv
`timescale 1ns/1ps
module test_wdg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, rst_full, irq, wdog_out;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [31:0] KEY = 32'h0000_4755;

    always #2 clk = ~clk;

    wdg_top i_wdg_top (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .rst_full(rst_full), .irq(irq), .wdog_out(wdog_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL all watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(4'hC, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(4'h4, rd); check("R1 reload", rd, 32'hFFFF_FFFF);
        bus_read(4'h0, rd); check("R1 count", rd, 32'hFFFF_FFFF);
        check("R1 outputs", {28'h0, rst_req, rst_full, irq, wdog_out}, 32'h0);

        // R2 register access
        bus_write(4'hC, 32'hFFFF_FFBE);
        bus_read(4'hC, rd); check("R2 ctrl bits 5:0 only", rd, 32'h3E);
        bus_write(4'hC, 32'h0);
        bus_read(4'h8, rd); check("R2 restart reads zero", rd, 32'h0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, rd); check("R2 status write ignored", rd, 32'hFFFF_FFFF);
        bus_write(4'h5, 32'h1234);
        bus_read(4'h4, rd); check("R2 misaligned write ignored", rd, 32'hFFFF_FFFF);
        bus_read(4'h5, rd); check("R2 misaligned read zero", rd, 32'h0);
        bus_write(4'h4, 32'h10);
        bus_read(4'h4, rd); check("R2 reload stored", rd, 32'h10);

        // R4 near-miss keys
        bus_write(4'h8, 32'h0000_4756);
        bus_read(4'h0, rd); check("R4 wrong key", rd, 32'hFFFF_FFFF);
        bus_write(4'h8, 32'h0001_4755);
        bus_read(4'h0, rd); check("R4 upper bits set", rd, 32'hFFFF_FFFF);
        check("R4 outputs", {29'h0, rst_req, irq, wdog_out}, 32'h0);

        // R3 key while idle
        bus_write(4'h8, KEY);
        bus_read(4'h0, rd); check("R3 key reload", rd, 32'h10);

        // R5 disabled hold
        repeat (5) edge1();
        bus_read(4'h0, rd); check("R5 hold while disabled", rd, 32'h10);

        // R6 start latency and rate
        bus_write(4'h4, 32'd100);
        bus_write(4'h8, KEY);
        bus_write(4'hC, 32'h1);
        edge1();
        check("R6 no decrement first edge", i_wdg_top.bus_rdata, 32'h0);
        bus_sel = 1'b1; bus_addr = 4'h0; #0.1;
        check("R6 count after 1 edge", bus_rdata, 32'd100);
        bus_sel = 1'b0;
        repeat (9) edge1();
        bus_sel = 1'b1; bus_addr = 4'h0; #0.1;
        check("R6 count after 10 edges", bus_rdata, 32'd91);
        bus_sel = 1'b0;
        bus_write(4'hC, 32'h0);

        // R8 zero count never expires
        bus_write(4'h4, 32'h0);
        bus_write(4'h8, KEY);
        bus_write(4'hC, 32'h0F);
        for (int k = 0; k < 20; k++) begin
            edge1();
            check("R8 zero reload no alarm", {29'h0, rst_req, irq, wdog_out}, 32'h0);
        end
        bus_read(4'h0, rd); check("R8 zero stays", rd, 32'h0);

        // R6 R7 R8 R9 R10 R11 sweep
        for (int tsel = 0; tsel < 2; tsel++) begin
            for (int scope = 0; scope < 2; scope++) begin
                for (int act = 0; act < 8; act++) begin
                    for (int L = 1; L <= 4; L++) begin
                        int remain;
                        int k;
                        logic fired;
                        logic [31:0] cw;
                        cw = {26'h0, scope[0], tsel[0], act[2:0], 1'b1};
                        bus_write(4'hC, 32'h0);
                        check("R10 clear by disable", {30'h0, irq, wdog_out}, 32'h0);
                        bus_write(4'h4, 32'(L));
                        bus_write(4'h8, KEY);
                        bus_write(4'hC, cw);
                        remain = L;
                        fired = 1'b0;
                        k = 0;
                        while (!fired && k < 200) begin
                            logic t;
                            k++;
                            t = (tsel == 0) ? 1'b0 : ((k % 3) == 1);
                            @(negedge clk);
                            tick_1us = t;
                            edge1();
                            if (k >= 2 && (tsel == 0 || t)) remain--;
                            if (remain == 0) begin
                                fired = 1'b1;
                                check("R9 reset pulse", {31'h0, rst_req}, {31'h0, act[0]});
                                check("R9 scope", {31'h0, rst_full}, 32'(scope));
                                check("R10 irq set", {31'h0, irq}, {31'h0, act[1]});
                                check("R10 ext set", {31'h0, wdog_out}, {31'h0, act[2]});
                            end else begin
                                check("R11 no early alarm", {29'h0, rst_req, irq, wdog_out}, 32'h0);
                            end
                        end
                        @(negedge clk);
                        tick_1us = 1'b1;
                        edge1();
                        tick_1us = 1'b0;
                        check("R9 pulse one cycle", {31'h0, rst_req}, 32'h0);
                        check("R10 irq held", {31'h0, irq}, {31'h0, act[1]});
                        bus_read(4'h0, rd); check("R8 held at zero", rd, 32'h0);
                        if (act[0] == 1'b0 && ((L % 2) == 0)) begin
                            bus_write(4'h8, KEY);
                            check("R3 key clears levels", {30'h0, irq, wdog_out}, 32'h0);
                            bus_sel = 1'b1; bus_addr = 4'h0; #0.1;
                            check("R3 key reloads after expiry", bus_rdata, 32'(L));
                            bus_sel = 1'b0;
                        end
                    end
                end
            end
        end
        bus_write(4'hC, 32'h0);

        // R7 tick gating: no ticks, no decrement
        bus_write(4'h4, 32'd50);
        bus_write(4'h8, KEY);
        bus_write(4'hC, 32'h11);
        repeat (10) edge1();
        bus_read(4'h0, rd); check("R7 no tick holds", rd, 32'd50);
        bus_write(4'hC, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule